// File: doc/BRIEF.md
# Flash Access Protection Controller

This block stands between a flash controller and three requesters: the CPU, a debug port and an SPI slave port. Every flash request carries a source, an operation (read, write, page erase) and an address. A permission check decides at once whether the request is forwarded to the flash controller or refused. The check uses a small register file with four fields: a 4-bit modification key, a secure bit, a 7-bit page number that marks where the protected upper code region starts, and a 2-bit bank select. A sticky violation flag records that something was refused. In special flash mode the SPI port may program the flash. Each single-byte SPI transaction in that mode loads the bank select, so the SPI port can reach all four 32 KB banks of the 128 KB array.

The request side is a valid/ready stream. The requester must hold `req_valid` and the request fields steady until `req_ready` is seen high at a clock edge. A granted request passes straight through: `fl_valid` follows `req_valid` and `req_ready` follows `fl_ready`, so back-pressure from the flash controller reaches the requester unchanged. A refused write or erase is consumed at once. A refused read is answered with all-ones data on the read return path in the cycle it is accepted. It waits while the flash controller is returning data on that path. Register accesses and SPI bank bytes use plain strobes.

Top module: `flash_guard`

## Requirements
- R1: After reset the key, secure bit, code-region page, bank select and violation flag all read back as 0.
- R2: A write (op 1) or erase (op 2) is forwarded only while the key field equals 2. With any of the other fifteen values it is refused.
- R3: The key keeps its value after a granted write or erase. It changes only through a register write to the key field (select 0).
- R4: While the secure bit (select 1, bit 0) is 1, erasing page 0 is refused, whoever asks.
- R5: While the secure bit is 1, erasing any 1 KB page whose number (address bits 16:10) is at or above the code-region page (select 2) is refused. Pages below it may be erased. With the secure bit at 0, erases are not limited by page.
- R6: While the secure bit is 1, reads from the debug port (source 1) and the SPI port (source 2) are refused, while CPU reads (source 0) still pass.
- R7: Outside special flash mode every SPI flash request is refused. In special flash mode SPI flash requests follow R2 to R6, and any SPI register access is refused: the write is dropped and the read data is all ones.
- R8: In special flash mode a single-byte SPI strobe copies its 2-bit command into the bank select at the next edge. Outside the mode the strobe is ignored. An SPI flash address is the bank select followed by the low 15 request address bits.
- R9: Any refused request or refused register access sets the violation flag (select 4, bit 0). It stays set until a register write of 1 to that bit. A new refusal in the same cycle as that clear leaves it set.
- R10: A granted request passes through: `fl_valid` = `req_valid`, `req_ready` = `fl_ready`, `grant` marks the transfer. A refused request is accepted with `deny` high. For a refused read, `rd_valid` is high with all-ones data in that cycle, and acceptance is held off while `fl_rvalid` is high.
- R11: Source code 3 and operation code 3 are always refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also applied on wake-up |
| req_valid | input | 1 | Flash request valid |
| req_ready | output | 1 | Flash request accepted |
| req_src | input | 2 | 0 CPU, 1 debug, 2 SPI, 3 reserved |
| req_op | input | 2 | 0 read, 1 write, 2 page erase, 3 reserved |
| req_addr | input | 17 | Byte address (SPI: low 15 bits used) |
| fl_valid | output | 1 | Forwarded request valid |
| fl_ready | input | 1 | Flash controller ready |
| fl_op | output | 2 | Forwarded operation |
| fl_addr | output | 17 | Forwarded physical address |
| fl_rvalid | input | 1 | Flash read data valid |
| fl_rdata | input | 32 | Flash read data |
| rd_valid | output | 1 | Read data to requester valid |
| rd_data | output | 32 | Read data to requester |
| grant | output | 1 | Granted request transferred this cycle |
| deny | output | 1 | Refused request accepted this cycle |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | Register access is a write |
| cfg_src | input | 2 | Register access source, same coding as req_src |
| cfg_sel | input | 3 | 0 key, 1 secure, 2 code page, 3 bank, 4 status |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 7 | Register read data for cfg_sel |
| sfm | input | 1 | Special flash mode |
| spi_byte_valid | input | 1 | Single-byte SPI transaction strobe |
| spi_cmd | input | 2 | Command field of that byte |
| viol | output | 1 | Sticky violation flag |

## Verification
The violation flag has a set path and a clear path, and both can act in the same cycle. A refused flash request and a status write of 1 are driven together at one clock edge. The flag is then read back and must still be 1. A lone clear written afterwards must bring it to 0. In the same way a refused read is presented while the flash controller holds `fl_rvalid`: it must wait with `req_ready` low and the flash data passing through, and it must be answered with all ones in the first free cycle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    SRC_CPU = 2'd0,
    SRC_DBG = 2'd1,
    SRC_SPI = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSV   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    SEL_KEY  = 3'd0,
    SEL_SEC  = 3'd1,
    SEL_LOC  = 3'd2,
    SEL_BANK = 3'd3,
    SEL_STAT = 3'd4
  } sel_e;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import flash_guard_pkg::*;
#(
  parameter int KEY_W  = 4,
  parameter int LOC_W  = 7,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic              cfg_blocked,
  input  logic [2:0]        cfg_sel,
  input  logic [LOC_W-1:0]  cfg_wdata,
  input  logic              sfm,
  input  logic              spi_byte_valid,
  input  logic [BANK_W-1:0] spi_cmd,
  input  logic              viol_set,
  output logic [KEY_W-1:0]  key,
  output logic              secure,
  output logic [LOC_W-1:0]  loc,
  output logic [BANK_W-1:0] bank,
  output logic              viol,
  output logic [LOC_W-1:0]  cfg_rdata
);
  localparam int CFG_W = LOC_W;

  logic wr, clr;
  assign wr  = cfg_en & cfg_we & ~cfg_blocked;
  assign clr = wr & (cfg_sel == SEL_STAT) & cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key    <= '0;
      secure <= 1'b0;
      loc    <= '0;
      bank   <= '0;
      viol   <= 1'b0;
    end else begin
      if (wr && cfg_sel == SEL_KEY) key <= cfg_wdata[KEY_W-1:0];
      if (wr && cfg_sel == SEL_SEC) secure <= cfg_wdata[0];
      if (wr && cfg_sel == SEL_LOC) loc <= cfg_wdata;
      if (sfm && spi_byte_valid) bank <= spi_cmd;
      else if (wr && cfg_sel == SEL_BANK) bank <= cfg_wdata[BANK_W-1:0];
      if (viol_set) viol <= 1'b1;
      else if (clr) viol <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_blocked) cfg_rdata = '1;
    else begin
      case (cfg_sel)
        SEL_KEY:  cfg_rdata = {{(CFG_W-KEY_W){1'b0}}, key};
        SEL_SEC:  cfg_rdata = {{(CFG_W-1){1'b0}}, secure};
        SEL_LOC:  cfg_rdata = loc;
        SEL_BANK: cfg_rdata = {{(CFG_W-BANK_W){1'b0}}, bank};
        SEL_STAT: cfg_rdata = {{(CFG_W-1){1'b0}}, viol};
        default:  cfg_rdata = '0;
      endcase
    end
  end

  AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && cfg_we && !cfg_blocked && cfg_sel == SEL_KEY) |=> $stable(key)); // R3
  AST_BANK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (sfm && spi_byte_valid) |=> bank == $past(spi_cmd)); // R8
  AST_VIOL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_set |=> viol); // R9
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !(cfg_en && cfg_we && cfg_sel == SEL_STAT)) |=> viol); // R9
endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import flash_guard_pkg::*;
#(
  parameter int KEY_W      = 4,
  parameter int UNLOCK_VAL = 2,
  parameter int LOC_W      = 7,
  parameter int BANK_W     = 2,
  parameter int OFF_W      = 15,
  parameter int PAGE_LG    = 10
) (
  input  logic [1:0]              src,
  input  logic [1:0]              op,
  input  logic [BANK_W+OFF_W-1:0] addr,
  input  logic [KEY_W-1:0]        key,
  input  logic                    secure,
  input  logic [LOC_W-1:0]        loc,
  input  logic [BANK_W-1:0]       bank,
  input  logic                    sfm,
  output logic                    allow,
  output logic [BANK_W+OFF_W-1:0] phys
);
  localparam int ADDR_W = BANK_W + OFF_W;

  logic             is_spi, is_mod, key_ok, reserved;
  logic             spi_blk, rd_blk, er_blk, mod_blk;
  logic [LOC_W-1:0] page;

  assign is_spi   = (src == SRC_SPI);
  assign phys     = is_spi ? {bank, addr[OFF_W-1:0]} : addr;
  assign page     = phys[ADDR_W-1:PAGE_LG];
  assign reserved = (src == SRC_RSV) | (op == OP_RSV);
  assign is_mod   = (op == OP_WRITE) | (op == OP_ERASE);
  assign key_ok   = (key == KEY_W'(UNLOCK_VAL));
  assign spi_blk  = is_spi & ~sfm;
  assign mod_blk  = is_mod & ~key_ok;
  assign rd_blk   = (op == OP_READ) & secure & (src != SRC_CPU);
  assign er_blk   = (op == OP_ERASE) & secure & ((page == '0) | (page >= loc));
  assign allow    = ~(reserved | spi_blk | mod_blk | rd_blk | er_blk);
endmodule

// File: rtl/fg_port.sv
module fg_port
  import flash_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  logic [1:0]        op,
  input  logic              allow,
  input  logic              fl_ready,
  input  logic              fl_rvalid,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              req_ready,
  output logic              fl_valid,
  output logic              grant,
  output logic              deny,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic is_rd, deny_rd;

  assign is_rd     = (op == OP_READ);
  assign fl_valid  = req_valid & allow;
  assign req_ready = allow ? fl_ready : ~(is_rd & fl_rvalid);
  assign grant     = fl_valid & fl_ready;
  assign deny      = req_valid & ~allow & req_ready;
  assign deny_rd   = deny & is_rd;
  assign rd_valid  = fl_rvalid | deny_rd;
  assign rd_data   = deny_rd ? '1 : fl_rdata;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int KEY_W      = 4,
  parameter int UNLOCK_VAL = 2,
  parameter int LOC_W      = 7,
  parameter int BANK_W     = 2,
  parameter int OFF_W      = 15,
  parameter int PAGE_LG    = 10,
  parameter int DATA_W     = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_src,
  input  logic [1:0]              req_op,
  input  logic [BANK_W+OFF_W-1:0] req_addr,
  output logic                    fl_valid,
  input  logic                    fl_ready,
  output logic [1:0]              fl_op,
  output logic [BANK_W+OFF_W-1:0] fl_addr,
  input  logic                    fl_rvalid,
  input  logic [DATA_W-1:0]       fl_rdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    grant,
  output logic                    deny,
  input  logic                    cfg_en,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_src,
  input  logic [2:0]              cfg_sel,
  input  logic [LOC_W-1:0]        cfg_wdata,
  output logic [LOC_W-1:0]        cfg_rdata,
  input  logic                    sfm,
  input  logic                    spi_byte_valid,
  input  logic [BANK_W-1:0]       spi_cmd,
  output logic                    viol
);
  localparam int ADDR_W = BANK_W + OFF_W;

  logic [KEY_W-1:0]  key;
  logic              secure;
  logic [LOC_W-1:0]  loc;
  logic [BANK_W-1:0] bank;
  logic              allow, cfg_blocked, viol_set;

  assign cfg_blocked = cfg_en & (cfg_src == SRC_SPI) & sfm;
  assign viol_set    = deny | cfg_blocked;
  assign fl_op       = req_op;

  fg_regs #(.KEY_W(KEY_W), .LOC_W(LOC_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_blocked(cfg_blocked), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .sfm(sfm), .spi_byte_valid(spi_byte_valid), .spi_cmd(spi_cmd),
    .viol_set(viol_set), .key(key), .secure(secure), .loc(loc),
    .bank(bank), .viol(viol), .cfg_rdata(cfg_rdata)
  );

  fg_policy #(.KEY_W(KEY_W), .UNLOCK_VAL(UNLOCK_VAL), .LOC_W(LOC_W),
              .BANK_W(BANK_W), .OFF_W(OFF_W), .PAGE_LG(PAGE_LG)) u_policy (
    .src(req_src), .op(req_op), .addr(req_addr), .key(key),
    .secure(secure), .loc(loc), .bank(bank), .sfm(sfm),
    .allow(allow), .phys(fl_addr)
  );

  fg_port #(.DATA_W(DATA_W)) u_port (
    .req_valid(req_valid), .op(req_op), .allow(allow), .fl_ready(fl_ready),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata), .req_ready(req_ready),
    .fl_valid(fl_valid), .grant(grant), .deny(deny),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_MOD_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && req_op != OP_READ) |-> key == KEY_W'(UNLOCK_VAL)); // R2
  AST_SEC_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && req_op == OP_ERASE && secure) |-> fl_addr[ADDR_W-1:PAGE_LG] != '0); // R4
  AST_SEC_READ_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && req_op == OP_READ && secure) |-> req_src == SRC_CPU); // R6
  AST_SPI_NEEDS_SFM: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && req_src == SRC_SPI) |-> sfm); // R7
  AST_NO_GRANT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny)); // R10
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_src = '0;
  logic [1:0]  req_op = '0;
  logic [16:0] req_addr = '0;
  logic        fl_valid;
  logic        fl_ready = 1'b1;
  logic [1:0]  fl_op;
  logic [16:0] fl_addr;
  logic        fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        grant, deny;
  logic        cfg_en = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_src = '0;
  logic [2:0]  cfg_sel = '0;
  logic [6:0]  cfg_wdata = '0;
  logic [6:0]  cfg_rdata;
  logic        sfm = 1'b0;
  logic        spi_byte_valid = 1'b0;
  logic [1:0]  spi_cmd = '0;
  logic        viol;

  int n_run = 0, n_fail = 0;
  logic [3:0] key_s = '0;
  logic       sec_s = 1'b0;
  logic [6:0] loc_s = '0;
  logic [1:0] bank_s = '0;
  logic       viol_s = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(input logic [1:0] s, input logic [1:0] o, input logic [16:0] a);
    logic [16:0] p;
    p = (s == 2'd2) ? {bank_s, a[14:0]} : a;
    if (s == 2'd3 || o == 2'd3) return 1'b0;                    // R11
    if (s == 2'd2 && !sfm) return 1'b0;                         // R7
    if (o != 2'd0 && key_s != 4'd2) return 1'b0;                // R2
    if (o == 2'd0 && sec_s && s != 2'd0) return 1'b0;           // R6
    if (o == 2'd2 && sec_s && (p[16:10] == 7'd0 || p[16:10] >= loc_s)) return 1'b0; // R4 R5
    return 1'b1;
  endfunction

  function automatic logic [16:0] exp_phys(input logic [1:0] s, input logic [16:0] a);
    return (s == 2'd2) ? {bank_s, a[14:0]} : a;
  endfunction

  task automatic cfg_write(input logic [1:0] s, input logic [2:0] sel, input logic [6:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_src = s; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    if (s == 2'd2 && sfm) viol_s = 1'b1;
    else case (sel)
      3'd0: key_s = d[3:0];
      3'd1: sec_s = d[0];
      3'd2: loc_s = d;
      3'd3: bank_s = d[1:0];
      3'd4: if (d[0]) viol_s = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] s, input logic [2:0] sel, output logic [6:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b0; cfg_src = s; cfg_sel = sel;
    #1 d = cfg_rdata;
    @(posedge clk);
    if (s == 2'd2 && sfm) viol_s = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic spi_byte(input logic [1:0] c);
    @(negedge clk);
    spi_byte_valid = 1'b1; spi_cmd = c;
    @(posedge clk);
    if (sfm) bank_s = c;
    @(negedge clk);
    spi_byte_valid = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] s, input logic [1:0] o, input logic [16:0] a, input string req);
    bit e;
    @(negedge clk);
    req_valid = 1'b1; req_src = s; req_op = o; req_addr = a; fl_ready = 1'b1;
    e = exp_allow(s, o, a);
    #1;
    chk(fl_valid == e && deny == !e && grant == e, req, {fl_valid, deny, grant}, {e, !e, e});
    if (e) chk(fl_addr == exp_phys(s, a), {req, " addr"}, fl_addr, exp_phys(s, a));
    else if (o == 2'd0) chk(rd_valid && rd_data == '1, {req, " R10 ones"}, rd_data, 32'hFFFF_FFFF);
    @(posedge clk);
    if (!e) viol_s = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_reg(input logic [2:0] sel, input logic [6:0] exp, input string req);
    logic [6:0] d;
    cfg_read(2'd0, sel, d);
    chk(d == exp, req, d, exp);
  endtask

  initial begin
    logic [6:0] d;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    chk_reg(3'd0, 7'd0, "R1 key");
    chk_reg(3'd1, 7'd0, "R1 secure");
    chk_reg(3'd2, 7'd0, "R1 loc");
    chk_reg(3'd3, 7'd0, "R1 bank");
    chk_reg(3'd4, 7'd0, "R1 viol");
    // R2: sweep all key values
    for (int k = 0; k < 16; k++) begin
      cfg_write(2'd0, 3'd0, 7'(k));
      do_req(2'd0, 2'd1, 17'h00400, "R2 write");
      do_req(2'd0, 2'd2, 17'h01400, "R2 erase");
    end
    // R3: key survives a granted erase
    cfg_write(2'd0, 3'd0, 7'd2);
    do_req(2'd0, 2'd2, 17'h02000, "R3 erase");
    chk_reg(3'd0, 7'd2, "R3 key kept");
    cfg_write(2'd0, 3'd4, 7'd1);
    // R4, R5: secure boundary sweep
    cfg_write(2'd0, 3'd2, 7'd40);
    do_req(2'd0, 2'd2, 17'd0, "R5 unsecured page0");
    do_req(2'd0, 2'd2, 17'(41) << 10, "R5 unsecured above");
    cfg_write(2'd0, 3'd1, 7'd1);
    do_req(2'd0, 2'd2, 17'd0, "R4 page0");
    do_req(2'd1, 2'd2, 17'h003FF, "R4 page0 dbg");
    do_req(2'd0, 2'd2, 17'(39) << 10, "R5 below");
    do_req(2'd0, 2'd2, 17'(40) << 10, "R5 at");
    do_req(2'd0, 2'd2, 17'(41) << 10, "R5 above");
    do_req(2'd0, 2'd1, 17'(41) << 10, "R5 write above");
    // R6: reads under secure
    do_req(2'd0, 2'd0, 17'h1F000, "R6 cpu read");
    do_req(2'd1, 2'd0, 17'h00010, "R6 dbg read");
    sfm = 1'b1;
    do_req(2'd2, 2'd0, 17'h00010, "R6 spi read");
    sfm = 1'b0;
    cfg_write(2'd0, 3'd1, 7'd0);
    do_req(2'd1, 2'd0, 17'h00010, "R6 dbg read open");
    // R7: SPI modes
    do_req(2'd2, 2'd0, 17'h00020, "R7 spi normal read");
    do_req(2'd2, 2'd1, 17'h00020, "R7 spi normal write");
    sfm = 1'b1;
    do_req(2'd2, 2'd1, 17'h00020, "R7 spi sfm write");
    cfg_write(2'd0, 3'd4, 7'd1);
    cfg_write(2'd2, 3'd0, 7'd5);
    chk(viol == 1'b1, "R7 cfg deny sets viol", viol, 1);
    cfg_read(2'd2, 3'd0, d);
    chk(d == 7'h7F, "R7 spi cfg read ones", d, 7'h7F);
    sfm = 1'b0;
    chk_reg(3'd0, 7'd2, "R7 key not written");
    // R8: bank copy and address composition
    spi_byte(2'd3);
    chk_reg(3'd3, 7'd0, "R8 ignored outside mode");
    sfm = 1'b1;
    spi_byte(2'd3);
    chk_reg(3'd3, 7'd3, "R8 bank copy");
    do_req(2'd2, 2'd0, 17'h0ABCD, "R8 spi addr");
    spi_byte(2'd1);
    do_req(2'd2, 2'd1, 17'h1FFFF, "R8 spi addr bank1");
    sfm = 1'b0;
    // R9: set and clear collide
    cfg_write(2'd0, 3'd4, 7'd1);
    chk(viol == 1'b0, "R9 cleared", viol, 0);
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd3; req_op = 2'd0; req_addr = '0;
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_src = 2'd0; cfg_sel = 3'd4; cfg_wdata = 7'd1;
    @(negedge clk);
    req_valid = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0;
    chk(viol == 1'b1, "R9 set wins", viol, 1);
    cfg_write(2'd0, 3'd4, 7'd1);
    chk(viol == 1'b0, "R9 lone clear", viol, 0);
    viol_s = 1'b0;
    // R10: back-pressure both ways
    @(negedge clk);
    req_valid = 1'b1; req_src = 2'd0; req_op = 2'd0; req_addr = 17'h00100; fl_ready = 1'b0;
    #1 chk(fl_valid && !req_ready && !grant, "R10 stall", {fl_valid, req_ready, grant}, 3'b100);
    @(negedge clk);
    fl_ready = 1'b1;
    #1 chk(grant && req_ready, "R10 release", {grant, req_ready}, 2'b11);
    @(negedge clk);
    req_src = 2'd3; fl_rvalid = 1'b1; fl_rdata = 32'h1234_5678;
    #1 chk(!req_ready && !deny && rd_valid && rd_data == 32'h1234_5678, "R10 deny waits",
           {req_ready, deny, rd_data}, {2'b00, 32'h1234_5678});
    @(negedge clk);
    fl_rvalid = 1'b0;
    #1 chk(deny && rd_valid && rd_data == '1, "R10 deny ones", rd_data, 32'hFFFF_FFFF);
    @(negedge clk);
    req_valid = 1'b0;
    viol_s = 1'b1;
    // R11: reserved codes
    cfg_write(2'd0, 3'd1, 7'd0);
    do_req(2'd3, 2'd0, 17'h00000, "R11 src3");
    do_req(2'd0, 2'd3, 17'h00000, "R11 op3");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) cfg_write(2'd0, 3'd0, ($urandom_range(0, 1) != 0) ? 7'd2 : 7'($urandom_range(0, 15)));
      else if (r == 1) cfg_write(2'd0, 3'd1, 7'($urandom_range(0, 1)));
      else if (r == 2) cfg_write(2'd0, 3'd2, 7'($urandom_range(0, 127)));
      else if (r == 3) sfm = ($urandom_range(0, 1) != 0);
      else if (r == 4) spi_byte(2'($urandom_range(0, 3)));
      do_req(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 17'($urandom), "R2 R5 R6 R7 random");
    end
    chk_reg(3'd4, {6'd0, viol_s}, "R9 random viol");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule